// File: doc/BRIEF.md
# External Trigger Pulse Converter

This block turns a single asynchronous logic-level input into two internal trigger pulses with fixed timing between them. The input is first resynchronised to the local clock, and its rising edges are detected. An accepted edge produces a one-cycle fast trigger at once. After a programmable number of clock cycles, a one-cycle event trigger follows. To the shared trigger lines downstream, the pair looks like another acquisition channel that saw a pulse and whose pile-up inspection window equals the programmed delay.

A delay setting of zero turns the converter off. The block also needs a sharing enable before it drives either trigger. While a delay is being counted, further input edges are dropped. The delay value is captured at the moment an edge is accepted, so a new setting written mid-count does not affect the event trigger that is already pending.

Top module: `ext_trig_converter`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `fast_trig_o` and `event_trig_o` are both 0.
- R2: Suppose `ext_in` rises between two clock edges, the delay is nonzero, sharing is on and no delay is running. Then `fast_trig_o` goes high in the cycle that follows the third rising clock edge after the input change. This accounts for two synchroniser stages and one output register.
- R3: `event_trig_o` goes high exactly D cycles after the cycle in which `fast_trig_o` was high, where D is the captured delay (1 to 65535).
- R4: A rising edge seen while `delay_cfg` is 0 produces neither trigger and starts no delay.
- R5: A rising edge seen while `share_en` is 0 produces neither trigger. An event trigger whose emission cycle finds `share_en` at 0 is dropped.
- R6: A rising edge detected while a delay is running is ignored. It yields no fast trigger, and it neither restarts nor moves the pending event trigger.
- R7: The delay is captured when the edge is accepted. Changing `delay_cfg` during the count does not move the event trigger.
- R8: Each trigger is a single-cycle pulse. An input held high produces only one pair.
- R9: The first rising edge after the event trigger has been issued is accepted normally and produces a new pair.
- R10: The largest delay value, 65535, gives an event trigger exactly 65535 cycles after the fast trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | Asynchronous external trigger level |
| share_en | input | 1 | Enables driving triggers onto the shared lines |
| delay_cfg | input | 16 | Validation delay in clock cycles; 0 disables the block |
| fast_trig_o | output | 1 | One-cycle fast trigger pulse |
| event_trig_o | output | 1 | One-cycle event trigger pulse, delayed |

## Verification
Single edges are driven with delays of 1, 5, 37 and 65535. These show whether the countdown is off by one at its smallest and largest values, and whether the fixed synchroniser latency is right. A second edge inside the count window, a long high level, and an edge right after the event trigger separate correct dropping of busy-time edges from missed re-arming. A zero delay, sharing held off, sharing dropped mid-count, and a delay rewritten mid-count show whether each gate acts on acceptance, on emission, or on both.

// File: rtl/exttrig_pkg.sv
package exttrig_pkg;

  typedef enum logic [0:0] {
    TMR_IDLE  = 1'b0,
    TMR_COUNT = 1'b1
  } tmr_state_t;

  // An edge starts a trigger pair only when every gate is open.
  function automatic logic edge_accepted(input logic rise,
                                         input logic share,
                                         input logic dly_nonzero,
                                         input logic busy);
    return rise & share & dly_nonzero & ~busy;
  endfunction

  // Rising edge from the current and previous synchronised level.
  function automatic logic rising(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // The countdown ends on the cycle its value is one.
  function automatic logic count_final(input logic running, input logic is_one);
    return running & is_one;
  endfunction

endpackage

// File: rtl/exttrig_sync.sv
module exttrig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o,
  output logic rise_o
);
  import exttrig_pkg::*;

  logic [STAGES-1:0] chain;
  logic              prev_lvl;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else        prev_lvl <= chain[STAGES-1];
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = rising(chain[STAGES-1], prev_lvl);

endmodule

// File: rtl/exttrig_timer.sv
module exttrig_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] load_i,
  output logic         busy_o,
  output logic         expire_o,
  output logic [W-1:0] held_o
);
  import exttrig_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  tmr_state_t   state;
  logic [W-1:0] remain;
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= TMR_IDLE;
      remain <= '0;
      held   <= '0;
    end else begin
      case (state)
        TMR_IDLE: begin
          if (start_i) begin
            state  <= TMR_COUNT;
            remain <= load_i;
            held   <= load_i;
          end
        end
        TMR_COUNT: begin
          if (remain == ONE) state <= TMR_IDLE;
          remain <= remain - ONE;
        end
        default: state <= TMR_IDLE;
      endcase
    end
  end

  assign busy_o   = (state == TMR_COUNT);
  assign expire_o = count_final(state == TMR_COUNT, remain == ONE);
  assign held_o   = held;

endmodule

// File: rtl/exttrig_out.sv
module exttrig_out (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_fast_i,
  input  logic fire_event_i,
  input  logic share_i,
  output logic fast_o,
  output logic event_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_o  <= 1'b0;
      event_o <= 1'b0;
    end else begin
      fast_o  <= fire_fast_i;
      event_o <= fire_event_i & share_i;
    end
  end

endmodule

// File: rtl/ext_trig_converter.sv
module ext_trig_converter #(
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_in,
  input  logic             share_en,
  input  logic [DLY_W-1:0] delay_cfg,
  output logic             fast_trig_o,
  output logic             event_trig_o
);
  import exttrig_pkg::*;

  logic             sync_level;
  logic             sync_rise;
  logic             edge_accept;
  logic             timer_busy;
  logic             timer_expire;
  logic [DLY_W-1:0] held_delay;

  exttrig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_in),
    .level_o  (sync_level),
    .rise_o   (sync_rise)
  );

  assign edge_accept = edge_accepted(sync_rise, share_en, |delay_cfg, timer_busy);

  exttrig_timer #(.W(DLY_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (edge_accept),
    .load_i   (delay_cfg),
    .busy_o   (timer_busy),
    .expire_o (timer_expire),
    .held_o   (held_delay)
  );

  exttrig_out u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_fast_i  (edge_accept),
    .fire_event_i (timer_expire),
    .share_i      (share_en),
    .fast_o       (fast_trig_o),
    .event_o      (event_trig_o)
  );

endmodule

// File: rtl/exttrig_chk.sv
module exttrig_chk #(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             share_en,
  input logic [DLY_W-1:0] delay_cfg,
  input logic             fast_trig_o,
  input logic             event_trig_o,
  input logic             timer_busy,
  input logic [DLY_W-1:0] held_delay
);

  logic           run;
  logic [DLY_W:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      age <= '0;
    end else if (fast_trig_o) begin
      run <= 1'b1;
      age <= (DLY_W+1)'(1);
    end else if (run && age != '1) begin
      age <= age + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !fast_trig_o && !event_trig_o);

  assert_fast_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fast_trig_o |=> !fast_trig_o);

  assert_event_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    event_trig_o |=> !event_trig_o);

  assert_event_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    event_trig_o |-> run && (age == {1'b0, held_delay}));

  assert_zero_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fast_trig_o |-> $past(delay_cfg) != '0);

  assert_share_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_trig_o || event_trig_o) |-> $past(share_en));

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fast_trig_o |-> $rose(timer_busy));

  assert_delay_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_busy && $past(timer_busy)) |-> $stable(held_delay));

endmodule

bind ext_trig_converter exttrig_chk #(.DLY_W(DLY_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .share_en     (share_en),
  .delay_cfg    (delay_cfg),
  .fast_trig_o  (fast_trig_o),
  .event_trig_o (event_trig_o),
  .timer_busy   (timer_busy),
  .held_delay   (held_delay)
);

// File: tb/ext_trig_converter_test.sv
module ext_trig_converter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_in = 1'b0;
  logic        share_en = 1'b1;
  logic [15:0] delay_cfg = 16'd0;
  logic        fast_trig_o;
  logic        event_trig_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nfast = 0, nevt = 0, fcyc = -1, ecyc = -1;
  bit done = 0;

  ext_trig_converter uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_in       (ext_in),
    .share_en     (share_en),
    .delay_cfg    (delay_cfg),
    .fast_trig_o  (fast_trig_o),
    .event_trig_o (event_trig_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fast_trig_o)  begin nfast++; fcyc = cyc; end
      if (event_trig_o) begin nevt++;  ecyc = cyc; end
    end
  end

  task automatic chk(input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, actual, expected);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic clear();
    nfast = 0; nevt = 0; fcyc = -1; ecyc = -1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    idle(1);
    chk("R1 fast low in reset", int'(fast_trig_o), 0);
    chk("R1 event low in reset", int'(event_trig_o), 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 fast low after release", int'(fast_trig_o), 0);
    chk("R1 event low after release", int'(event_trig_o), 0);
  endtask

  task automatic t_single(input int d, input string tag);
    int c;
    clear();
    delay_cfg = 16'(d);
    share_en = 1'b1;
    @(negedge clk);
    c = cyc;
    ext_in = 1'b1;
    idle(d + 10);
    ext_in = 1'b0;
    idle(4);
    chk({tag, " R2 fast count"}, nfast, 1);
    chk({tag, " R2 fast cycle"}, fcyc, c + 3);
    chk({tag, " R3 event cycle"}, ecyc, c + 3 + d);
    chk({tag, " R8 event count"}, nevt, 1);
  endtask

  task automatic t_zero();
    clear();
    delay_cfg = 16'd0;
    @(negedge clk);
    ext_in = 1'b1;
    idle(20);
    ext_in = 1'b0;
    idle(3);
    chk("R4 no fast when delay zero", nfast, 0);
    chk("R4 no event when delay zero", nevt, 0);
  endtask

  task automatic t_share_off();
    clear();
    delay_cfg = 16'd6;
    share_en = 1'b0;
    @(negedge clk);
    ext_in = 1'b1;
    idle(20);
    ext_in = 1'b0;
    idle(3);
    chk("R5 no fast while sharing off", nfast, 0);
    chk("R5 no event while sharing off", nevt, 0);
    share_en = 1'b1;
    idle(2);
    clear();
    delay_cfg = 16'd8;
    @(negedge clk);
    ext_in = 1'b1;
    idle(5);
    share_en = 1'b0;
    idle(15);
    ext_in = 1'b0;
    chk("R5 fast before sharing dropped", nfast, 1);
    chk("R5 event dropped after sharing off", nevt, 0);
    share_en = 1'b1;
    idle(4);
  endtask

  task automatic t_busy_edges();
    int c, c2;
    clear();
    delay_cfg = 16'd20;
    @(negedge clk);
    c = cyc;
    ext_in = 1'b1;
    idle(5);
    ext_in = 1'b0;
    idle(3);
    ext_in = 1'b1;
    idle(25);
    chk("R6 second edge gives no fast", nfast, 1);
    chk("R6 event not moved", ecyc, c + 23);
    chk("R6 single event", nevt, 1);
    ext_in = 1'b0;
    idle(3);
    @(negedge clk);
    c2 = cyc;
    ext_in = 1'b1;
    idle(6);
    chk("R9 new edge accepted", nfast, 2);
    chk("R9 new fast cycle", fcyc, c2 + 3);
    idle(20);
    chk("R9 new event cycle", ecyc, c2 + 23);
    ext_in = 1'b0;
    idle(3);
  endtask

  task automatic t_latch();
    int c;
    clear();
    delay_cfg = 16'd10;
    @(negedge clk);
    c = cyc;
    ext_in = 1'b1;
    idle(6);
    delay_cfg = 16'd3;
    idle(12);
    ext_in = 1'b0;
    idle(2);
    chk("R7 event uses captured delay", ecyc, c + 13);
    chk("R7 single event", nevt, 1);
  endtask

  task automatic t_level();
    clear();
    delay_cfg = 16'd4;
    @(negedge clk);
    ext_in = 1'b1;
    idle(40);
    chk("R8 held level one fast", nfast, 1);
    chk("R8 held level one event", nevt, 1);
    ext_in = 1'b0;
    idle(3);
  endtask

  initial begin
    idle(3);
    t_reset();
    idle(2);
    t_single(5, "d5");
    t_single(1, "d1");
    t_single(37, "d37");
    t_zero();
    t_share_off();
    t_busy_edges();
    t_latch();
    t_level();
    t_single(65535, "R10 d65535");
    report();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    report();
  end

endmodule